// File: doc/BRIEF.md
# Decode Stage Skid-Buffer Controller

This block is the flow-control core of a single-thread instruction decode stage. Every cycle it may receive a bundle of up to `FETCH_W` instruction lanes from fetch. It forwards up to `DECODE_W` of them to the next stage, packed into output slots from slot 0 upward. Lanes that are invalid, or that arrive already marked as killed, are discarded and take no output slot.

Three later stages (rename, execute, commit) raise one-cycle block and unblock pulses. Each pulse pair drives a sticky stall flag. While any flag is set, the stage is blocked: arriving instructions go into a skid FIFO, and fetch is told once to hold off. When the stall lifts, the FIFO drains oldest first. Anything fetch sends during the drain joins the back of the FIFO. Fetch is told it may resume only when the FIFO is empty again.

A squash request from commit overrides everything else. It empties the FIFO and puts the stage into a squashing state. The stage stays there while commit reports that its reorder buffer is still busy squashing. The FIFO depth is set to the fetch latency times the fetch width, plus the decode width. Every output is registered and follows its inputs by one clock.

Top module: `dec_skid_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and after it, `status` reads Idle (code 0), `skid_level` is 0, and `out_valid`, `out_data`, `fetch_block`, `fetch_unblock` and `overflow_err` are all zero.
- R2: The skid FIFO holds at most `FETCH_LAT*FETCH_W + DECODE_W` entries, and `skid_level` never exceeds that figure.
- R3: Each of rename, execute and commit has a sticky stall flag. Its block pulse sets the flag and its unblock pulse clears it; unblock wins when both pulses arrive together. The stage is stalled whenever any flag is set.
- R4: `cmt_squash` has top priority. It empties the FIFO, forwards nothing, drops the arriving lanes and sets `status` to Squashing (code 4). While `cmt_rob_busy` is high without a squash, `status` stays at Squashing and nothing is forwarded.
- R5: While stalled, the kept arriving lanes are pushed to the FIFO in lane order, nothing is forwarded, and `status` becomes Blocked (code 2). `fetch_block` pulses only if the previous status was neither Blocked nor Unblocking.
- R6: Leaving Blocked with no stall, the stage enters Unblocking (code 3) and starts draining in that same cycle. Leaving Squashing with no stall, no squash and no busy reorder buffer, the stage enters Running (code 1) and forwards arriving lanes in that same cycle.
- R7: During Unblocking, output slots are filled from the FIFO, oldest first, up to `DECODE_W`, and the kept arriving lanes are appended to the FIFO. When the FIFO is empty at the end of the cycle, `fetch_unblock` pulses and `status` becomes Running.
- R8: In Idle, Running or Squashing, the kept arriving lanes are forwarded in lane order, up to `DECODE_W`. Any lanes left over go to the FIFO, `status` becomes Blocked and `fetch_block` pulses. Idle moves to Running on the first forwarded lane.
- R9: A lane whose `in_valid` bit is 0, or whose `in_killed` bit is 1, is dropped. It uses neither an output slot nor a FIFO entry.
- R10: A squash arriving while in Blocked or Unblocking pulses `fetch_unblock`. `fetch_block` is never high in the same cycle as `fetch_unblock`.
- R11: `out_valid` is packed from bit 0 with no gaps. `out_data` lanes whose valid bit is clear read zero. Each lane carries `DATA_W` bits, lane k at bits `k*DATA_W` upward.
- R12: If a push would exceed the FIFO capacity, the entries that fit are kept in order, the rest are discarded, and `overflow_err` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | FETCH_W | Per-lane valid bits of the fetch bundle |
| in_killed | input | FETCH_W | Per-lane marker: instruction already squashed |
| in_data | input | FETCH_W*DATA_W | Lane payloads, lane k at bits k*DATA_W |
| ren_block | input | 1 | Rename stall-set pulse |
| ren_unblock | input | 1 | Rename stall-clear pulse |
| exe_block | input | 1 | Execute stall-set pulse |
| exe_unblock | input | 1 | Execute stall-clear pulse |
| cmt_block | input | 1 | Commit stall-set pulse |
| cmt_unblock | input | 1 | Commit stall-clear pulse |
| cmt_squash | input | 1 | Squash request from commit |
| cmt_rob_busy | input | 1 | Commit reorder buffer still squashing |
| out_valid | output | DECODE_W | Forwarded slot valid bits, packed from bit 0 |
| out_data | output | DECODE_W*DATA_W | Forwarded slot payloads |
| fetch_block | output | 1 | Hold-off pulse to fetch |
| fetch_unblock | output | 1 | Resume pulse to fetch |
| status | output | 3 | Idle 0, Running 1, Blocked 2, Unblocking 3, Squashing 4 |
| skid_level | output | LVL_W | Current FIFO occupancy |
| overflow_err | output | 1 | FIFO capacity exceeded this cycle |

## Verification
The delicate coincidence is a squash landing in the same cycle as a fresh block pulse while the stage is Blocked or Unblocking. The bench forces this directly: it raises `ren_block` and `cmt_squash` together right after a stall. It then expects `fetch_unblock` high, `fetch_block` low and an empty FIFO. The second coincidence is a drain cycle in which popping from the FIFO and appending new fetch lanes happen together, near full capacity. That case is provoked by long stall bursts during random traffic. In every cycle, the slot contents, the FIFO level and the overflow pulse are compared against a queue-based model kept in the bench.

// File: rtl/dec_skid_pkg.sv
package dec_skid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RUN  = 3'd1,
        ST_BLK  = 3'd2,
        ST_UNB  = 3'd3,
        ST_SQ   = 3'd4
    } dsk_state_e;

endpackage

// File: rtl/dsk_stall_track.sv
module dsk_stall_track #(
    parameter int SRCS = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SRCS-1:0] blk,
    input  logic [SRCS-1:0] unblk,
    output logic            stall_now
);

    logic [SRCS-1:0] flags_d, flags_q;

    // unblock wins over block arriving in the same cycle
    always_comb begin
        flags_d   = (flags_q | blk) & ~unblk;
        stall_now = |flags_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

endmodule

// File: rtl/dsk_lane_pack.sv
module dsk_lane_pack #(
    parameter int LANES  = 4,
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]  valid,
    input  logic [LANES-1:0]  killed,
    input  logic [DATA_W-1:0] lane    [LANES],
    output logic [DATA_W-1:0] pk_data [LANES],
    output logic [CNT_W-1:0]  pk_cnt
);

    logic [LANES-1:0] keep;
    assign keep = valid & ~killed;

    // each kept lane lands in the slot equal to its rank among kept lanes
    always_comb begin
        int rank;
        rank = 0;
        for (int j = 0; j < LANES; j++) pk_data[j] = '0;
        for (int i = 0; i < LANES; i++) begin
            if (keep[i]) begin
                for (int j = 0; j < LANES; j++) begin
                    if (j == rank) pk_data[j] = lane[i];
                end
                rank = rank + 1;
            end
        end
        pk_cnt = CNT_W'(rank);
    end

endmodule

// File: rtl/dsk_skid_fifo.sv
module dsk_skid_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 6,
    parameter int PUSH_W = 4,
    parameter int POP_W  = 2,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PN_W  = $clog2(PUSH_W + 1),
    localparam int QN_W  = $clog2(POP_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [PN_W-1:0]   push_n,
    input  logic [DATA_W-1:0] push_data [PUSH_W],
    input  logic [QN_W-1:0]   pop_n,
    output logic [DATA_W-1:0] rd_data   [POP_W],
    output logic [LVL_W-1:0]  level
);

    function automatic logic [IDX_W-1:0] wrap(input int p);
        return IDX_W'(p % DEPTH);
    endfunction

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0]  head_d, head_q;
    logic [LVL_W-1:0]  lvl_d, lvl_q;

    always_comb begin
        for (int i = 0; i < POP_W; i++) rd_data[i] = mem_q[wrap(int'(head_q) + i)];
        if (clr) begin
            head_d = '0;
            lvl_d  = '0;
        end else begin
            head_d = wrap(int'(head_q) + int'(pop_n));
            lvl_d  = LVL_W'(int'(lvl_q) + int'(push_n) - int'(pop_n));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            lvl_q  <= '0;
        end else begin
            head_q <= head_d;
            lvl_q  <= lvl_d;
        end
    end

    // tail position is taken before the pop; freed head slots are reusable
    always_ff @(posedge clk) begin
        if (!clr) begin
            for (int i = 0; i < PUSH_W; i++) begin
                if (i < int'(push_n))
                    mem_q[wrap(int'(head_q) + int'(lvl_q) + i)] <= push_data[i];
            end
        end
    end

    assign level = lvl_q;

endmodule

// File: rtl/dec_skid_ctrl.sv
module dec_skid_ctrl
    import dec_skid_pkg::*;
#(
    parameter int FETCH_W   = 4,
    parameter int DECODE_W  = 2,
    parameter int FETCH_LAT = 1,
    parameter int DATA_W    = 16,
    localparam int SKID_DEPTH = FETCH_LAT * FETCH_W + DECODE_W,
    localparam int LVL_W      = $clog2(SKID_DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [FETCH_W-1:0]         in_valid,
    input  logic [FETCH_W-1:0]         in_killed,
    input  logic [FETCH_W*DATA_W-1:0]  in_data,
    input  logic                       ren_block,
    input  logic                       ren_unblock,
    input  logic                       exe_block,
    input  logic                       exe_unblock,
    input  logic                       cmt_block,
    input  logic                       cmt_unblock,
    input  logic                       cmt_squash,
    input  logic                       cmt_rob_busy,
    output logic [DECODE_W-1:0]        out_valid,
    output logic [DECODE_W*DATA_W-1:0] out_data,
    output logic                       fetch_block,
    output logic                       fetch_unblock,
    output logic [2:0]                 status,
    output logic [LVL_W-1:0]           skid_level,
    output logic                       overflow_err
);

    localparam int PN_W = $clog2(FETCH_W + 1);
    localparam int QN_W = $clog2(DECODE_W + 1);

    typedef struct packed {
        dsk_state_e                  st;
        logic                        fblk;
        logic                        funb;
        logic                        ovf;
        logic [DECODE_W-1:0]         ov;
        logic [DECODE_W*DATA_W-1:0]  od;
    } regs_t;

    regs_t r_d, r_q;

    // ---------------- lane split and packing ----------------
    logic [DATA_W-1:0] lane_in [FETCH_W];
    logic [DATA_W-1:0] pk      [FETCH_W];
    logic [DATA_W-1:0] pk_head [DECODE_W];
    logic [DATA_W-1:0] pk_rest [FETCH_W];
    logic [PN_W-1:0]   pk_n;

    for (genvar g = 0; g < FETCH_W; g++) begin : g_lane
        assign lane_in[g] = in_data[g*DATA_W +: DATA_W];
    end

    dsk_lane_pack #(
        .LANES  (FETCH_W),
        .DATA_W (DATA_W)
    ) u_pack (
        .valid   (in_valid),
        .killed  (in_killed),
        .lane    (lane_in),
        .pk_data (pk),
        .pk_cnt  (pk_n)
    );

    // first DECODE_W packed lanes feed the slots, the rest may spill
    for (genvar g = 0; g < DECODE_W; g++) begin : g_head
        if (g < FETCH_W) begin : g_have
            assign pk_head[g] = pk[g];
        end else begin : g_none
            assign pk_head[g] = '0;
        end
    end

    for (genvar g = 0; g < FETCH_W; g++) begin : g_rest
        if (g + DECODE_W < FETCH_W) begin : g_have
            assign pk_rest[g] = pk[g + DECODE_W];
        end else begin : g_none
            assign pk_rest[g] = '0;
        end
    end

    // ---------------- stall flags ----------------
    logic stall_now;

    dsk_stall_track #(
        .SRCS (3)
    ) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk       ({cmt_block, exe_block, ren_block}),
        .unblk     ({cmt_unblock, exe_unblock, ren_unblock}),
        .stall_now (stall_now)
    );

    // ---------------- skid FIFO ----------------
    logic              sk_clr;
    logic [PN_W-1:0]   sk_push_n;
    logic [DATA_W-1:0] sk_push [FETCH_W];
    logic [QN_W-1:0]   sk_pop_n;
    logic [DATA_W-1:0] sk_rd   [DECODE_W];
    logic [LVL_W-1:0]  sk_lvl;

    dsk_skid_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (SKID_DEPTH),
        .PUSH_W (FETCH_W),
        .POP_W  (DECODE_W)
    ) u_skid (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sk_clr),
        .push_n    (sk_push_n),
        .push_data (sk_push),
        .pop_n     (sk_pop_n),
        .rd_data   (sk_rd),
        .level     (sk_lvl)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        int   n_in;
        int   n_req;
        int   n_pop;
        int   n_fwd;
        int   room;
        int   n_acc;
        logic drain;
        logic spill;

        r_d      = r_q;
        r_d.fblk = 1'b0;
        r_d.funb = 1'b0;
        r_d.ovf  = 1'b0;
        r_d.ov   = '0;
        r_d.od   = '0;
        n_in     = int'(pk_n);
        n_req    = 0;
        n_pop    = 0;
        n_fwd    = 0;
        drain    = 1'b0;
        spill    = 1'b0;
        sk_clr   = 1'b0;

        if (cmt_squash) begin
            sk_clr = 1'b1;
            if (r_q.st == ST_BLK || r_q.st == ST_UNB) r_d.funb = 1'b1;
            r_d.st = ST_SQ;
        end else if (cmt_rob_busy) begin
            r_d.st = ST_SQ;
        end else if (stall_now) begin
            n_req    = n_in;
            r_d.fblk = !(r_q.st == ST_BLK || r_q.st == ST_UNB);
            r_d.st   = ST_BLK;
        end else if (r_q.st == ST_BLK || r_q.st == ST_UNB) begin
            drain = 1'b1;
            n_pop = (int'(sk_lvl) < DECODE_W) ? int'(sk_lvl) : DECODE_W;
            n_fwd = n_pop;
            n_req = n_in;
        end else begin
            spill = 1'b1;
            n_fwd = (n_in < DECODE_W) ? n_in : DECODE_W;
            n_req = n_in - n_fwd;
            if (n_req > 0) begin
                r_d.st   = ST_BLK;
                r_d.fblk = 1'b1;
            end else if (n_fwd > 0 || r_q.st == ST_SQ) begin
                r_d.st = ST_RUN;
            end
        end

        room    = SKID_DEPTH - int'(sk_lvl) + n_pop;
        n_acc   = (n_req > room) ? room : n_req;
        r_d.ovf = (n_req > room);

        if (drain) begin
            if (int'(sk_lvl) - n_pop + n_acc == 0) begin
                r_d.st   = ST_RUN;
                r_d.funb = 1'b1;
            end else begin
                r_d.st = ST_UNB;
            end
        end

        for (int j = 0; j < DECODE_W; j++) begin
            if (j < n_fwd) begin
                r_d.ov[j] = 1'b1;
                r_d.od[j*DATA_W +: DATA_W] = drain ? sk_rd[j] : pk_head[j];
            end
        end

        for (int i = 0; i < FETCH_W; i++) sk_push[i] = spill ? pk_rest[i] : pk[i];
        sk_push_n = PN_W'(n_acc);
        sk_pop_n  = QN_W'(n_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid     = r_q.ov;
    assign out_data      = r_q.od;
    assign fetch_block   = r_q.fblk;
    assign fetch_unblock = r_q.funb;
    assign status        = r_q.st;
    assign skid_level    = sk_lvl;
    assign overflow_err  = r_q.ovf;

endmodule

// File: rtl/dec_skid_chk.sv
module dec_skid_chk
    import dec_skid_pkg::*;
#(
    parameter int DECODE_W = 2,
    parameter int DEPTH    = 6,
    parameter int LVL_W    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ren_block,
    input logic                ren_unblock,
    input logic                cmt_squash,
    input logic                cmt_rob_busy,
    input logic [DECODE_W-1:0] out_valid,
    input logic                fetch_block,
    input logic                fetch_unblock,
    input logic [2:0]          status,
    input logic [LVL_W-1:0]    skid_level
);

    // R11
    slot_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid & (out_valid + 1'b1)) == '0));

    // R5
    block_pulse_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_block |-> (status == ST_BLK));

    // R10
    block_unblock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_block && fetch_unblock));

    // R4
    squash_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash |=> (status == ST_SQ && skid_level == '0 && out_valid == '0 && !fetch_block));

    // R7
    unblock_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_unblock |-> (skid_level == '0));

    // R2
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(skid_level) <= DEPTH);

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_block && !ren_unblock && !cmt_squash && !cmt_rob_busy)
        |=> (status == ST_BLK && out_valid == '0));

endmodule

bind dec_skid_ctrl dec_skid_chk #(
    .DECODE_W (DECODE_W),
    .DEPTH    (SKID_DEPTH),
    .LVL_W    (LVL_W)
) u_dec_skid_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ren_block     (ren_block),
    .ren_unblock   (ren_unblock),
    .cmt_squash    (cmt_squash),
    .cmt_rob_busy  (cmt_rob_busy),
    .out_valid     (out_valid),
    .fetch_block   (fetch_block),
    .fetch_unblock (fetch_unblock),
    .status        (status),
    .skid_level    (skid_level)
);

// File: tb/dec_skid_ctrl_bench.sv
module dec_skid_ctrl_bench;

    localparam int CLK_P     = 10;
    localparam int FW        = 4;
    localparam int DW        = 2;
    localparam int LAT       = 1;
    localparam int DATA_W    = 16;
    localparam int DEPTH     = LAT * FW + DW;
    localparam int LVL_W     = $clog2(DEPTH + 1);
    localparam int S_IDLE = 0, S_RUN = 1, S_BLK = 2, S_UNB = 3, S_SQ = 4;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [FW-1:0]          in_valid, in_killed;
    logic [FW*DATA_W-1:0]   in_data;
    logic ren_block, ren_unblock, exe_block, exe_unblock, cmt_block, cmt_unblock;
    logic cmt_squash, cmt_rob_busy;
    logic [DW-1:0]          out_valid;
    logic [DW*DATA_W-1:0]   out_data;
    logic                   fetch_block, fetch_unblock, overflow_err;
    logic [2:0]             status;
    logic [LVL_W-1:0]       skid_level;

    always #(CLK_P/2) clk = ~clk;

    dec_skid_ctrl #(
        .FETCH_W (FW), .DECODE_W (DW), .FETCH_LAT (LAT), .DATA_W (DATA_W)
    ) u_dec_skid_ctrl (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_killed (in_killed), .in_data (in_data),
        .ren_block (ren_block), .ren_unblock (ren_unblock),
        .exe_block (exe_block), .exe_unblock (exe_unblock),
        .cmt_block (cmt_block), .cmt_unblock (cmt_unblock),
        .cmt_squash (cmt_squash), .cmt_rob_busy (cmt_rob_busy),
        .out_valid (out_valid), .out_data (out_data),
        .fetch_block (fetch_block), .fetch_unblock (fetch_unblock),
        .status (status), .skid_level (skid_level), .overflow_err (overflow_err)
    );

    // ---------------- reference model ----------------
    int              m_st;
    bit [2:0]        m_flags;
    int              m_q[$];
    bit [DW-1:0]     e_ov;
    bit [DW*DATA_W-1:0] e_od;
    bit              e_fb, e_fu, e_ovf;

    int    n_chk, n_fail;
    string cur_req;
    bit    done;

    function automatic void emit(int slot, int val);
        e_ov[slot] = 1'b1;
        e_od[slot*DATA_W +: DATA_W] = DATA_W'(val);
    endfunction

    function automatic void push_all(int items[$]);
        foreach (items[i]) begin
            if (m_q.size() < DEPTH) m_q.push_back(items[i]);
            else e_ovf = 1'b1;
        end
    endfunction

    function automatic void model_step();
        int  lst[$];
        int  left[$];
        int  n;
        bit  stall;
        m_flags = (m_flags | {cmt_block, exe_block, ren_block})
                  & ~{cmt_unblock, exe_unblock, ren_unblock};
        stall = |m_flags;
        e_ov = '0; e_od = '0; e_fb = 0; e_fu = 0; e_ovf = 0;
        for (int i = 0; i < FW; i++)
            if (in_valid[i] && !in_killed[i]) lst.push_back(int'(in_data[i*DATA_W +: DATA_W]));
        if (cmt_squash) begin
            m_q.delete();
            if (m_st == S_BLK || m_st == S_UNB) e_fu = 1;
            m_st = S_SQ;
        end else if (cmt_rob_busy) begin
            m_st = S_SQ;
        end else if (stall) begin
            push_all(lst);
            if (m_st != S_BLK && m_st != S_UNB) e_fb = 1;
            m_st = S_BLK;
        end else if (m_st == S_BLK || m_st == S_UNB) begin
            n = 0;
            while (n < DW && m_q.size() > 0) begin
                emit(n, m_q.pop_front());
                n++;
            end
            push_all(lst);
            if (m_q.size() == 0) begin m_st = S_RUN; e_fu = 1; end
            else m_st = S_UNB;
        end else begin
            n = 0;
            foreach (lst[i]) begin
                if (n < DW) begin emit(n, lst[i]); n++; end
                else left.push_back(lst[i]);
            end
            if (left.size() > 0) begin push_all(left); m_st = S_BLK; e_fb = 1; end
            else if (n > 0 || m_st == S_SQ) m_st = S_RUN;
        end
    endfunction

    task automatic chk(string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("out_valid", longint'(out_valid), longint'(e_ov));
        chk("out_data", longint'(out_data), longint'(e_od));
        chk("fetch_block", longint'(fetch_block), longint'(e_fb));
        chk("fetch_unblock", longint'(fetch_unblock), longint'(e_fu));
        chk("status", longint'(status), longint'(m_st));
        chk("skid_level", longint'(skid_level), longint'(m_q.size()));
        chk("overflow_err", longint'(overflow_err), longint'(e_ovf));
    endtask

    task automatic quiet();
        in_valid = '0; in_killed = '0; in_data = '0;
        ren_block = 0; ren_unblock = 0; exe_block = 0; exe_unblock = 0;
        cmt_block = 0; cmt_unblock = 0; cmt_squash = 0; cmt_rob_busy = 0;
    endtask

    task automatic lanes(logic [FW-1:0] v, logic [FW-1:0] k);
        in_valid = v; in_killed = k;
        for (int i = 0; i < FW; i++) in_data[i*DATA_W +: DATA_W] = DATA_W'($urandom);
    endtask

    // inputs are already driven at a falling edge; outputs checked one edge later
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        quiet();
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'd4242);
        n_chk = 0; n_fail = 0; done = 0;
        quiet();
        rst_n = 1'b0;
        m_st = S_IDLE; m_flags = '0; m_q.delete();
        e_ov = '0; e_od = '0; e_fb = 0; e_fu = 0; e_ovf = 0;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare();
        rst_n = 1'b1;

        // R8: four lanes from Idle: two forwarded, two spill, block to fetch
        cur_req = "R8"; lanes(4'b1111, 4'b0000); step();
        // R6: stall gone while Blocked: drains at once; R7: empties, unblocks fetch
        cur_req = "R6"; step();
        cur_req = "R7"; lanes(4'b0001, 4'b0000); step();
        // R9: invalid and killed lanes take no slot
        cur_req = "R9"; lanes(4'b1011, 4'b0010); step();
        cur_req = "R9"; lanes(4'b1111, 4'b1111); step();
        // R3: sticky flag set by one pulse, held without pulses
        cur_req = "R3"; ren_block = 1; lanes(4'b0011, 4'b0000); step();
        // R5: repeated stalled cycles push, fetch_block only once
        cur_req = "R5"; lanes(4'b0011, 4'b0000); step();
        // R12: overflow beyond capacity
        cur_req = "R12"; lanes(4'b1111, 4'b0000); step();
        // R3: rename clears but execute now holds the stall
        cur_req = "R3"; ren_unblock = 1; exe_block = 1; lanes(4'b0001, 4'b0000); step();
        // R7: drain while fetch keeps appending
        cur_req = "R7"; exe_unblock = 1; lanes(4'b0011, 4'b0000); step();
        cur_req = "R7"; lanes(4'b0001, 4'b0000); step();
        // R10: squash and new block pulse in the same cycle during Unblocking
        cur_req = "R10"; cmt_squash = 1; ren_block = 1; lanes(4'b1111, 4'b0000); step();
        // R4: reorder buffer still busy holds Squashing; clear the rename flag meanwhile
        cur_req = "R4"; cmt_rob_busy = 1; ren_unblock = 1; lanes(4'b1111, 4'b0000); step();
        cur_req = "R4"; cmt_rob_busy = 1; lanes(4'b0011, 4'b0000); step();
        // R6: leaving Squashing forwards in the same cycle
        cur_req = "R6"; lanes(4'b0110, 4'b0000); step();
        // R2: long stall fills to capacity
        cur_req = "R2"; cmt_block = 1; lanes(4'b1111, 4'b0000); step();
        for (int c = 0; c < 3; c++) begin
            cur_req = "R2"; lanes(4'b1111, 4'b0000); step();
        end
        cur_req = "R7"; cmt_unblock = 1; step();
        for (int c = 0; c < 4; c++) begin
            cur_req = "R7"; step();
        end

        // R11: constrained random traffic
        cur_req = "R11";
        for (int c = 0; c < 4000; c++) begin
            lanes(FW'($urandom), FW'($urandom) & FW'($urandom) & FW'($urandom));
            ren_block    = ($urandom % 14) == 0;
            ren_unblock  = ($urandom % 5) == 0;
            exe_block    = ($urandom % 20) == 0;
            exe_unblock  = ($urandom % 5) == 0;
            cmt_block    = ($urandom % 25) == 0;
            cmt_unblock  = ($urandom % 4) == 0;
            cmt_squash   = ($urandom % 45) == 0;
            cmt_rob_busy = ($urandom % 25) == 0;
            step();
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule